// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Occupancy Flags

This block is a single-clock first-in/first-out buffer for 9-bit words. The spare ninth bit can carry parity or a marker at the user's choice. A producer presents words with a write enable and a consumer takes them with a read enable. Both enables are sampled on the rising clock edge. The block refuses any access that would overrun or underrun its storage, and it reports three status levels: empty, full and more-than-half-full.

A rewind input returns the read position to the first storage location and keeps the write position where it is. A block of data written since reset can therefore be played out again. This is useful for resending a packet that fits inside the buffer. All three flags follow the new distance between the two positions.

Read data is registered. An accepted read presents its word on `rdData` just after the clock edge that took it, and the word stays there until the next accepted read.

Top module: `rtfifo_top`

## Requirements
- R1: Words leave in the order they were written, each `DATA_W` (default 9) bits wide and unaltered.
- R2: While `rstN` is low, both positions return to location zero. After reset, `emptyFlag`=1, `fullFlag`=0, `halfFlag`=0 and `rdData`=0.
- R3: A write while `fullFlag`=1 is dropped, and the stored contents and write position stay unchanged.
- R4: A read while `emptyFlag`=1 is dropped, and `rdData` and the read position stay unchanged.
- R5: `emptyFlag` is 1 exactly when occupancy is zero. With no reads after reset, `fullFlag` rises after exactly `DEPTH` accepted writes and not before.
- R6: `halfFlag` is 1 exactly when occupancy exceeds `DEPTH/2`. It sets on the write that takes occupancy to `DEPTH/2+1` and clears on the read that brings it back to `DEPTH/2`.
- R7: A rewind cycle moves the read position to location zero and keeps the write position. The flags then reflect the new occupancy, and later reads replay the words from the first one written after reset.
- R8: In a rewind cycle, `wrEn` and `rdEn` are ignored: nothing is stored and `rdData` does not change.
- R9: `rdData` changes only on the edge of an accepted read. It holds its value through idle and blocked cycles.
- R10: A read and a write in the same cycle, both allowed, leave occupancy unchanged. When empty, only the write takes effect. When full, only the read takes effect.
- R11: A word written into an empty buffer can be read on the next cycle. A slot freed by a read from a full buffer can be written on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request for this cycle |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request for this cycle |
| rewind | input | 1 | Return the read position to location zero |
| rdData | output | DATA_W | Most recently read word |
| emptyFlag | output | 1 | No unread words |
| fullFlag | output | 1 | DEPTH unread words |
| halfFlag | output | 1 | More than DEPTH/2 unread words |

## Verification
The bench fills the buffer to exactly `DEPTH`. A design with an off-by-one full test would flag full one write early or would store a word past the limit and lose the oldest one. The half-full edge is checked on both sides of `DEPTH/2`, which exposes a `>=` comparison in place of `>`. Combined read and write requests are driven on a full buffer, on an empty buffer and on a partly filled one. A design that let the blocked side through would corrupt order or drift its occupancy. Rewind is issued while both strobes are high, and the replayed words are then compared with the original ones; a design that also reset the write position or obeyed the strobes would come back empty or replay the wrong words.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  // Strobes the control sends to the datapath for one clock cycle.
  typedef struct packed {
    logic push;  // store wrData at the write address
    logic pop;   // load rdData from the read address
  } fifo_strobe_t;
endpackage

// File: rtl/rtfifo_ctrl.sv
module rtfifo_ctrl
  import rtfifo_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic                       rewind,
  output fifo_strobe_t               strobe,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       emptyFlag,
  output logic                       fullFlag,
  output logic                       halfFlag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;                    // one extra wrap bit
  localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_OCC = PW'(DEPTH / 2);

  logic [PW-1:0] wrPtr, rdPtr, occ;

  // Occupancy is the wrap-aware pointer distance.
  assign occ       = wrPtr - rdPtr;
  assign emptyFlag = (occ == '0);
  assign fullFlag  = (occ == FULL_OCC);
  assign halfFlag  = (occ > HALF_OCC);

  // A rewind cycle overrides both strobes.
  assign strobe.push = wrEn && !fullFlag  && !rewind;
  assign strobe.pop  = rdEn && !emptyFlag && !rewind;

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (rewind) begin
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // R3: a write presented while full must not move the write pointer.
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag && wrEn |=> $stable(wrPtr));

  // R4: a read presented while empty must not move the read pointer.
  p_empty_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag && rdEn && !rewind |=> $stable(rdPtr));

  // R7: rewind lands the read pointer on zero and keeps the write pointer.
  p_rewind_r7: assert property (@(posedge clk) disable iff (!rstN)
    rewind |=> (rdPtr == '0) && $stable(wrPtr));

  // R10: outside rewind, occupancy moves by at most one per cycle.
  p_occ_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rewind |=> (occ == $past(occ)) || (occ == $past(occ) + 1'b1) ||
                (occ == $past(occ) - 1'b1));

  // R6: a full buffer is above the half mark and never empty.
  p_full_half_r6: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> halfFlag && !emptyFlag);
endmodule

// File: rtl/rtfifo_store.sv
module rtfifo_store
  import rtfifo_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fifo_strobe_t              strobe,
  input  logic [$clog2(DEPTH)-1:0]  wrAddr,
  input  logic [$clog2(DEPTH)-1:0]  rdAddr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Storage array, no reset needed.
  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  // Registered read port. A push and a pop in the same cycle never share
  // an address, because that happens only when empty or full.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

  // R9: read data holds unless the control issued a pop.
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/rtfifo_top.sv
module rtfifo_top
  import rtfifo_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rewind,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              halfFlag
);
  localparam int AW = $clog2(DEPTH);

  fifo_strobe_t     strobe;
  logic [AW-1:0]    wrAddr, rdAddr;

  rtfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .halfFlag(halfFlag)
  );

  rtfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/test_rtfifo_top.sv
`timescale 1ns/1ps
module test_rtfifo_top;
  localparam int DEPTH = 2048;
  localparam int DW    = 9;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rewind = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic emptyFlag, fullFlag, halfFlag;

  rtfifo_top #(.DEPTH(DEPTH), .DATA_W(DW)) i_rtfifo_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewind(rewind), .rdData(rdData), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .halfFlag(halfFlag)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;
  bit summaryDone = 0;

  // Reference model: every word written since reset plus a read index.
  logic [DW-1:0] hist[$];
  int            rdIdx = 0;
  logic [DW-1:0] expData = '0;

  function automatic int occ();
    return hist.size() - rdIdx;
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 37 + 5) % 512);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "emptyFlag", int'(emptyFlag), int'(occ() == 0));
    chk(tag, "fullFlag",  int'(fullFlag),  int'(occ() == DEPTH));
    chk(tag, "halfFlag",  int'(halfFlag),  int'(occ() > DEPTH / 2));
    chk(tag, "rdData",    int'(rdData),    int'(expData));
  endtask

  // Drive at a falling edge, update the model at the rising edge,
  // and return at the next falling edge, ready to check.
  task automatic step(bit w, logic [DW-1:0] d, bit r, bit rw);
    int o;
    wrEn = w; wrData = d; rdEn = r; rewind = rw;
    @(posedge clk);
    o = occ();
    if (rw) rdIdx = 0;
    else begin
      if (r && o != 0) begin expData = hist[rdIdx]; rdIdx++; end
      if (w && o != DEPTH) hist.push_back(d);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; rewind = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    hist.delete(); rdIdx = 0; expData = '0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    checkAll("R2");
  endtask

  task automatic tBasic();
    doReset();
    for (int i = 0; i < 5; i++) begin step(1, pat(i), 0, 0); checkAll("R1"); end
    step(0, '0, 0, 0); checkAll("R9");
    for (int i = 0; i < 5; i++) begin step(0, '0, 1, 0); checkAll("R1"); end
    step(0, '0, 0, 0); checkAll("R9");
  endtask

  task automatic tFlow();
    doReset();
    step(1, 9'h1A5, 0, 0); checkAll("R11");
    step(0, '0, 1, 0);     checkAll("R11");
    chk("R11", "flow-through word", int'(rdData), 'h1A5);
  endtask

  task automatic tEmptyRead();
    logic [DW-1:0] held;
    held = rdData;
    step(0, '0, 1, 0); checkAll("R4");
    step(0, '0, 1, 0); checkAll("R4");
    chk("R4", "rdData held", int'(rdData), int'(held));
  endtask

  task automatic tFill();
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      step(1, pat(i), 0, 0);
      checkAll("R5");
      if (i + 1 == DEPTH / 2)     chk("R6", "half at DEPTH/2", int'(halfFlag), 0);
      if (i + 1 == DEPTH / 2 + 1) chk("R6", "half at DEPTH/2+1", int'(halfFlag), 1);
      if (i + 1 == DEPTH - 1)     chk("R5", "full at DEPTH-1", int'(fullFlag), 0);
    end
    chk("R5", "full at DEPTH", int'(fullFlag), 1);
    step(1, 9'h0FF, 0, 0); checkAll("R3");
    step(1, 9'h111, 1, 0); checkAll("R10");
    step(1, 9'h122, 0, 0); checkAll("R11");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, '0, 1, 0);
      checkAll("R3");
      if (occ() == DEPTH / 2) chk("R6", "half clears at DEPTH/2", int'(halfFlag), 0);
    end
    chk("R3", "last drained word", int'(rdData), 'h122);
  endtask

  task automatic tSimul();
    doReset();
    for (int i = 0; i < 3; i++) step(1, pat(i + 50), 0, 0);
    for (int i = 0; i < 4; i++) begin step(1, pat(i + 60), 1, 0); checkAll("R10"); end
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
    checkAll("R10");
    step(1, 9'h0AB, 1, 0); checkAll("R10");
    chk("R10", "write-only on empty", int'(emptyFlag), 0);
  endtask

  task automatic tRewind();
    doReset();
    for (int i = 0; i < 10; i++) step(1, pat(i + 100), 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    step(1, 9'h055, 1, 1); checkAll("R8");
    for (int i = 0; i < 10; i++) begin step(0, '0, 1, 0); checkAll("R7"); end
    step(0, '0, 1, 0); checkAll("R7");
    doReset();
    for (int i = 0; i < DEPTH / 2 + 3; i++) step(1, pat(i + 7), 0, 0);
    for (int i = 0; i < DEPTH / 2 + 3; i++) step(0, '0, 1, 0);
    checkAll("R7");
    step(0, '0, 0, 1); checkAll("R7");
    chk("R7", "half after rewind", int'(halfFlag), 1);
    step(0, '0, 1, 0); checkAll("R7");
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    end
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tBasic();
    tFlow();
    tEmptyRead();
    tFill();
    tSimul();
    tRewind();
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule